// File: doc/BRIEF.md
# Subcarrier-Locked Line-Rate Divider with Phase Detector

This block produces a line-rate strobe by counting cycles of a clock that runs at four times the colour subcarrier frequency. That clock is about 14.318 MHz for the 525-line standard and about 17.734 MHz for the 625-line standard. A standard-select input sets the divide ratio. In 525-line mode every line lasts 910 clocks. In 625-line mode a line normally lasts 1135 clocks. An external line counter can raise a marker so that one line inside vertical blanking lasts 1137 clocks. This absorbs the fractional subcarrier cycles that build up over a field.

The block also contains a phase detector with a three-state output. It compares the rising edge of a reference line pulse with the rising edge of a comparison line pulse. It drives its output low when the comparison pulse is early, and high when the comparison pulse is late. It releases the output to high impedance when the two pulses are aligned. The three-state pin is modelled as a data bit and an output-enable bit, and the pad is placed outside this block. The block has no loop filter and no oscillator model.

All inputs are synchronous to the subcarrier-multiple clock.

Top module: `sc_hdiv_top`

## Requirements
- R1: With `std_sel` = 0 (525-line), successive `h_pulse` strobes are exactly 910 clocks apart, whatever the level of `vbl_line`.
- R2: With `std_sel` = 1 (625-line) and `vbl_line` low, successive strobes are 1135 clocks apart.
- R3: In 625-line mode the length of each line is decided by `vbl_line` in the last clock of the line before it. If the marker is high in that clock, the next line lasts 1137 clocks. If the marker is low in the last clock of the long line, the line after it returns to 1135 clocks.
- R4: `h_pulse` is high for exactly one clock. It rises in the clock after the counter reaches terminal count, which is the first clock of the new line.
- R5: While `rst` is high at a clock edge, `h_pulse`, `pd_oe` and `pd_data` go low and the counter clears. The first strobe after reset is seen L clock edges after the first edge with `rst` low, where L is the line length chosen by the inputs during reset.
- R6: A change of `std_sel` during a line does not alter the length of that line. It takes effect from the next line.
- R7: If the comparison pulse rises before the reference pulse, the output is driven low (`pd_oe`=1, `pd_data`=0) from the edge that first sees the comparison pulse high. It stays driven until the edge that first sees the reference pulse high, and then it releases (`pd_oe`=0). Extra comparison edges in between have no effect.
- R8: If the reference pulse rises before the comparison pulse, the output is driven high (`pd_oe`=1, `pd_data`=1) until the comparison rising edge is seen, and then it releases.
- R9: Rising edges of both pulses that are seen at the same clock edge leave the output at high impedance (`pd_oe`=0).
- R10: Whenever `pd_oe` is 0, `pd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Four-times-subcarrier clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | 0 = 525-line standard, 1 = 625-line standard |
| vbl_line | input | 1 | Long-line marker from the external line counter |
| ref_h | input | 1 | Reference horizontal pulse |
| cmp_h | input | 1 | Comparison horizontal pulse |
| h_pulse | output | 1 | One-clock line-rate strobe |
| pd_data | output | 1 | Phase detector level when driven |
| pd_oe | output | 1 | Phase detector drive enable (0 = high impedance) |

## Verification
The embedded properties check the following on every cycle:
- the strobe is one clock wide and lines up with the counter wrap;
- the counter never reaches the latched line length;
- the latched length is always one of the three legal values and changes only at a line boundary;
- the phase detector enters the correct driven or released state after each edge combination;
- the data bit is low while the output is released.

Only the bench scenarios can show the following:
- the exact line periods in each standard;
- which single line the marker lengthens;
- that a change of standard is deferred to the next line;
- the latency of the first strobe after reset.

// File: rtl/sc_hdiv_pkg.sv
package sc_hdiv_pkg;
  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_LEAD = 2'd1,
    PD_LAG  = 2'd2
  } pd_state_t;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/sc_hdiv_counter.sv
module sc_hdiv_counter #(
  parameter int NORM_525 = 910,
  parameter int NORM_625 = 1135,
  parameter int LONG_625 = 1137,
  parameter int CNT_W    = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic std_sel,
  input  logic vbl_line,
  output logic h_pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] len_q;
  logic [CNT_W-1:0] next_len;
  logic [CNT_W-1:0] term;

  always_comb begin
    if (!std_sel)
      next_len = CNT_W'(NORM_525);
    else if (vbl_line)
      next_len = CNT_W'(LONG_625);
    else
      next_len = CNT_W'(NORM_625);
  end

  assign term = len_q - CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      len_q   <= next_len;
      h_pulse <= 1'b0;
    end else if (cnt == term) begin
      cnt     <= '0;
      len_q   <= next_len;
      h_pulse <= 1'b1;
    end else begin
      cnt     <= cnt + CNT_W'(1);
      h_pulse <= 1'b0;
    end
  end

  AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (rst)
    cnt < len_q); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    h_pulse |=> !h_pulse); // R4
  AST_PULSE_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    h_pulse |-> (cnt == '0)); // R4
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (len_q == CNT_W'(NORM_525)) || (len_q == CNT_W'(NORM_625)) ||
    (len_q == CNT_W'(LONG_625))); // R3
  AST_LEN_HELD_MIDLINE: assert property (@(posedge clk) disable iff (rst)
    (cnt != '0) |-> $stable(len_q)); // R6
endmodule

// File: rtl/sc_hdiv_edge.sv
module sc_hdiv_edge (
  input  logic clk,
  input  logic rst,
  input  logic sig,
  output logic rise
);
  logic sig_q;

  // Reset loads the live level so a pulse held through reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) sig_q <= sig;
    else     sig_q <= sig;
  end

  assign rise = sig & ~sig_q;
endmodule

// File: rtl/sc_hdiv_phasecmp.sv
module sc_hdiv_phasecmp
  import sc_hdiv_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic cmp_rise,
  output logic pd_data,
  output logic pd_oe
);
  pd_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      PD_IDLE: begin
        if (cmp_rise && !ref_rise)      st_nx = PD_LEAD;
        else if (ref_rise && !cmp_rise) st_nx = PD_LAG;
      end
      PD_LEAD: if (ref_rise) st_nx = PD_IDLE;
      PD_LAG:  if (cmp_rise) st_nx = PD_IDLE;
      default: st_nx = PD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PD_IDLE;
      pd_oe   <= 1'b0;
      pd_data <= 1'b0;
    end else begin
      st      <= st_nx;
      pd_oe   <= (st_nx != PD_IDLE);
      pd_data <= (st_nx == PD_LAG);
    end
  end

  AST_LEAD_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == PD_IDLE && cmp_rise && !ref_rise) |=> (pd_oe && !pd_data)); // R7
  AST_LEAD_HELD: assert property (@(posedge clk) disable iff (rst)
    (pd_oe && !pd_data && !ref_rise) |=> (pd_oe && !pd_data)); // R7
  AST_LAG_DRIVES_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == PD_IDLE && ref_rise && !cmp_rise) |=> (pd_oe && pd_data)); // R8
  AST_LAG_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (pd_oe && pd_data && cmp_rise) |=> !pd_oe); // R8
  AST_INPHASE_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (st == PD_IDLE && ref_rise && cmp_rise) |=> !pd_oe); // R9
  AST_FLOAT_DATA_LOW: assert property (@(posedge clk) disable iff (rst)
    !pd_oe |-> !pd_data); // R10
endmodule

// File: rtl/sc_hdiv_top.sv
module sc_hdiv_top
  import sc_hdiv_pkg::*;
#(
  parameter int NORM_525 = 910,
  parameter int NORM_625 = 1135,
  parameter int LONG_625 = 1137
) (
  input  logic clk,
  input  logic rst,
  input  logic std_sel,
  input  logic vbl_line,
  input  logic ref_h,
  input  logic cmp_h,
  output logic h_pulse,
  output logic pd_data,
  output logic pd_oe
);
  localparam int MAX_LEN = max3(NORM_525, NORM_625, LONG_625);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam int N_EDGE  = 2;

  logic [N_EDGE-1:0] raw_in;
  logic [N_EDGE-1:0] rise;

  assign raw_in = {cmp_h, ref_h};

  for (genvar gi = 0; gi < N_EDGE; gi++) begin : g_edge
    sc_hdiv_edge u_edge (
      .clk  (clk),
      .rst  (rst),
      .sig  (raw_in[gi]),
      .rise (rise[gi])
    );
  end

  sc_hdiv_counter #(
    .NORM_525 (NORM_525),
    .NORM_625 (NORM_625),
    .LONG_625 (LONG_625),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .std_sel  (std_sel),
    .vbl_line (vbl_line),
    .h_pulse  (h_pulse)
  );

  sc_hdiv_phasecmp u_pd (
    .clk      (clk),
    .rst      (rst),
    .ref_rise (rise[0]),
    .cmp_rise (rise[1]),
    .pd_data  (pd_data),
    .pd_oe    (pd_oe)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    $past(rst) |-> (!h_pulse && !pd_oe)); // R5
endmodule

// File: tb/sc_hdiv_top_test.sv
module sc_hdiv_top_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic std_sel = 1'b0;
  logic vbl_line = 1'b0;
  logic ref_h = 1'b0;
  logic cmp_h = 1'b0;
  logic h_pulse, pd_data, pd_oe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sc_hdiv_top uut (
    .clk(clk), .rst(rst), .std_sel(std_sel), .vbl_line(vbl_line),
    .ref_h(ref_h), .cmp_h(cmp_h),
    .h_pulse(h_pulse), .pd_data(pd_data), .pd_oe(pd_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Clocks from now until the next strobe, sampled at falling edges.
  task automatic to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!h_pulse && n < 5000);
  endtask

  task automatic do_reset(input bit s);
    @(negedge clk);
    rst = 1'b1; std_sel = s; vbl_line = 1'b0; ref_h = 1'b0; cmp_h = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset;
    int n;
    @(negedge clk);
    rst = 1'b1; std_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(!h_pulse && !pd_oe && !pd_data, "R5 outputs in reset",
        {h_pulse, pd_oe, pd_data}, 0);
    rst = 1'b0;
    to_pulse(n);
    chk(n == 910, "R5 first strobe latency", n, 910);
    @(negedge clk);
    chk(!h_pulse, "R4 strobe one clock wide", h_pulse, 0);
  endtask

  task automatic t_525;
    int n;
    do_reset(1'b0);
    to_pulse(n);
    to_pulse(n);
    chk(n == 910, "R1 525 period", n, 910);
    vbl_line = 1'b1;
    to_pulse(n);
    chk(n == 910, "R1 525 period with marker high", n, 910);
    to_pulse(n);
    chk(n == 910, "R1 525 period with marker high again", n, 910);
    vbl_line = 1'b0;
  endtask

  task automatic t_625;
    int n;
    do_reset(1'b1);
    to_pulse(n);
    chk(n == 1135, "R5 first strobe latency 625", n, 1135);
    to_pulse(n);
    chk(n == 1135, "R2 625 period", n, 1135);
  endtask

  task automatic t_625_long;
    int n;
    do_reset(1'b1);
    to_pulse(n);
    vbl_line = 1'b1;
    to_pulse(n);
    chk(n == 1135, "R3 line carrying marker keeps 1135", n, 1135);
    vbl_line = 1'b0;
    to_pulse(n);
    chk(n == 1137, "R3 marked line is long", n, 1137);
    to_pulse(n);
    chk(n == 1135, "R3 following line back to 1135", n, 1135);
  endtask

  task automatic t_mode_switch;
    int n;
    do_reset(1'b1);
    to_pulse(n);
    std_sel = 1'b0;
    to_pulse(n);
    chk(n == 1135, "R6 line in progress keeps 625 length", n, 1135);
    to_pulse(n);
    chk(n == 910, "R6 new standard from next line", n, 910);
    std_sel = 1'b1;
    to_pulse(n);
    chk(n == 910, "R6 switch back deferred", n, 910);
    to_pulse(n);
    chk(n == 1135, "R6 625 resumes", n, 1135);
  endtask

  task automatic t_pd_lead;
    do_reset(1'b0);
    @(negedge clk);
    chk(!pd_oe && !pd_data, "R10 idle released", {pd_oe, pd_data}, 0);
    cmp_h = 1'b1;
    @(negedge clk);
    chk(pd_oe && !pd_data, "R7 lead drives low", {pd_oe, pd_data}, 2);
    cmp_h = 1'b0;
    @(negedge clk);
    cmp_h = 1'b1;
    repeat (2) @(negedge clk);
    chk(pd_oe && !pd_data, "R7 extra comparison edge ignored", {pd_oe, pd_data}, 2);
    ref_h = 1'b1;
    @(negedge clk);
    chk(!pd_oe && !pd_data, "R7 release on reference edge", {pd_oe, pd_data}, 0);
    ref_h = 1'b0; cmp_h = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pd_lag;
    ref_h = 1'b1;
    @(negedge clk);
    chk(pd_oe && pd_data, "R8 lag drives high", {pd_oe, pd_data}, 3);
    repeat (4) @(negedge clk);
    chk(pd_oe && pd_data, "R8 drive held", {pd_oe, pd_data}, 3);
    cmp_h = 1'b1;
    @(negedge clk);
    chk(!pd_oe && !pd_data, "R8 release on comparison edge", {pd_oe, pd_data}, 0);
    ref_h = 1'b0; cmp_h = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_pd_inphase;
    ref_h = 1'b1; cmp_h = 1'b1;
    @(negedge clk);
    chk(!pd_oe, "R9 aligned edges stay released", pd_oe, 0);
    repeat (3) @(negedge clk);
    chk(!pd_oe && !pd_data, "R9 still released", {pd_oe, pd_data}, 0);
    ref_h = 1'b0; cmp_h = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_525();
    t_625();
    t_625_long();
    t_mode_switch();
    t_pd_lead();
    t_pd_lag();
    t_pd_inphase();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule